// File: doc/BRIEF.md
# Paged Host Register Window Decoder

This block is the host-facing I/O decoder in the glue logic of a network adapter. The host sees a 16-byte I/O region. The lower eight bytes hold the adapter's own control registers. The upper eight bytes form a shared window. That window shows either the network controller's system-interface registers or a two-page identity ROM, and a mode bit in control register 0 picks which one.

The controller has sixteen byte locations but only two word-select lines reach it from the host address. A latched extension bit in control register 1 supplies the third select line. With it, the controller's upper eight bytes can be reached through the same host offsets as the lower eight.

Host requests enter on a valid/ready channel. A request is accepted on a clock edge where `h_valid` and `h_ready` are both high. Each accepted read produces exactly one response beat on `r_valid`/`r_data`, and that beat is held stable until `r_ready` is seen high. `h_ready` is low while an unconsumed response is being held, so there is at most one outstanding read. Writes produce no response.

Controller accesses take one cycle. Chip-select, the select lines and the byte enables are driven combinationally in the accept cycle. The controller's read data is sampled at that same edge.

Top module: `hostwin_decoder`

## Requirements
- R1: After reset the map bit, page bit, extension bit and cable output are all 0, no response is pending, and a read of every control offset returns 0x00.
- R2: Host offsets 0 to 7 are the control bank and can be reached whatever the mode. Offset 0 bit 2 is the map bit and offset 0 bit 3 is the page bit. Offset 1 bit 3 is the select extension bit. Offset 7 bit 0 is the cable select. All other bits, and offsets 2 to 6, read 0 and ignore writes. A word access at offset n covers bytes n&6 (low half) and n|1 (high half).
- R3: The `cable_utp` pin equals the last value written to offset 7 bit 0, starting the cycle after the write is accepted.
- R4: While the map bit is 0, host offsets 8 to 15 read from the identity ROM and `sif_cs` never asserts.
- R5: ROM page 0, selected by page bit = 0, holds byte 0 = 0x4D, byte 1 = card type, byte 2 = revision, and bytes 3, 4 and 5 = `cfg_mirror` bits [7:0], [15:8] and [23:16]. Bytes 6 and 7 read 0x00.
- R6: ROM page 1 holds `station_addr` in bytes 1 to 6, most significant byte first. Bytes 0 and 7 read 0x00.
- R7: A byte read returns its byte in `r_data[7:0]` with `r_data[15:8]` = 0. A word read at window offset n returns byte n&6 in bits [7:0] and byte n|1 in bits [15:8].
- R8: Writes to the window while the map bit is 0 change nothing: ROM reads and controller registers are unaffected, and there is no chip-select.
- R9: While the map bit is 1, each window access asserts `sif_cs` for exactly its accept cycle. `sif_rs` = {extension bit, offset[2:1]}. `sif_be` is 01 for an even-offset byte, 10 for an odd-offset byte and 11 for a word. Read data is taken from the selected lane.
- R10: On a controller write, `sif_we` is 1. A word write is passed through unchanged. A byte write places its byte on both lanes of `sif_wdata`.
- R11: While `r_valid` is 1 and `r_ready` is 0, `h_ready` is 0 and `r_data` holds. A read response appears the cycle after the read is accepted.
- R12: An accepted write never produces a response beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| h_valid | input | 1 | Host request valid |
| h_ready | output | 1 | Host request ready |
| h_write | input | 1 | 1 = write, 0 = read |
| h_word | input | 1 | 1 = 16-bit access, 0 = byte |
| h_addr | input | 4 | Host offset: 0-7 control bank, 8-15 window |
| h_wdata | input | 16 | Write data (byte writes use bits 7:0) |
| r_valid | output | 1 | Read response valid |
| r_ready | input | 1 | Read response accepted by host |
| r_data | output | 16 | Read response data |
| cfg_mirror | input | 24 | Configuration bytes mirrored into ROM page 0 |
| station_addr | input | 48 | Station address shown in ROM page 1 |
| sif_cs | output | 1 | Controller chip-select |
| sif_we | output | 1 | Controller write strobe |
| sif_rs | output | 3 | Controller word select {extension, offset[2:1]} |
| sif_be | output | 2 | Controller byte enables |
| sif_wdata | output | 16 | Controller write data |
| sif_rdata | input | 16 | Controller read data (combinational) |
| cable_utp | output | 1 | Cable interface select, 1 = unshielded |

## Verification
The bench steps through all sixteen combinations of map, page, extension and cable bits. The control bytes are written with their unused bits set, and under each combination every host offset is read as a byte and every even offset as a word. This separates the ROM view from the controller view, page 0 from page 1, and the lower controller bank from the upper one. The ROM sweep is repeated with a second set of configuration and station bytes, so a byte taken from the wrong position or in the wrong order shows up as a wrong value. Controller writes of both sizes, at both extension settings, are compared against a separate expected image of the bench's controller model. Window writes in ROM mode are then checked to leave both the ROM view and that model unchanged. A held response under a stalled `r_ready` tells correct back-pressure apart from a dropped or overwritten beat.

// File: rtl/hostwin_pkg.sv
package hostwin_pkg;
  localparam int BYTE_W    = 8;
  localparam int WORD_W    = 2 * BYTE_W;
  localparam int WIN_BYTES = 8;
  localparam int OFF_W     = $clog2(WIN_BYTES);
  localparam int HADDR_W   = OFF_W + 1;
  localparam int RS_W      = OFF_W;
  localparam int CFG_BYTES = 3;
  localparam int STA_BYTES = 6;

  // control bank layout
  localparam int CR_MODE_OFF   = 0;
  localparam int CR_EXT_OFF    = 1;
  localparam int CR_CABLE_OFF  = 7;
  localparam int MAP_BIT       = 2;
  localparam int PAGE_BIT      = 3;
  localparam int EXT_BIT       = 3;
  localparam int CABLE_BIT     = 0;

  // ROM layout
  localparam int ROM_CFG_BASE  = 3;
  localparam int ROM_STA_BASE  = 1;

  typedef struct packed {
    logic              write;
    logic              word;
    logic [OFF_W-1:0]  off;
    logic [WORD_W-1:0] wdata;
  } hw_access_t;
endpackage

// File: rtl/hw_ctl_bank.sv
module hw_ctl_bank
  import hostwin_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  hw_access_t        acc,
  output logic [WORD_W-1:0] rd_data,
  output logic              map_en,
  output logic              rom_page,
  output logic              rs_ext,
  output logic              cable_sel
);
  logic [BYTE_W-1:0] bank [WIN_BYTES];
  logic [BYTE_W-1:0] wr_byte [WIN_BYTES];
  logic [WIN_BYTES-1:0] wr_hit;
  logic [OFF_W-1:0] lo_idx, hi_idx, ii;

  assign lo_idx = acc.word ? {acc.off[OFF_W-1:1], 1'b0} : acc.off;
  assign hi_idx = {acc.off[OFF_W-1:1], 1'b1};

  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) bank[i] = '0;
    bank[CR_MODE_OFF][MAP_BIT]    = map_en;
    bank[CR_MODE_OFF][PAGE_BIT]   = rom_page;
    bank[CR_EXT_OFF][EXT_BIT]     = rs_ext;
    bank[CR_CABLE_OFF][CABLE_BIT] = cable_sel;
  end

  assign rd_data = acc.word ? {bank[hi_idx], bank[lo_idx]}
                            : {{BYTE_W{1'b0}}, bank[acc.off]};

  always_comb begin
    ii = '0;
    for (int i = 0; i < WIN_BYTES; i++) begin
      ii = OFF_W'(i);
      wr_hit[i]  = 1'b0;
      wr_byte[i] = '0;
      if (wr_en) begin
        if (acc.word) begin
          if (ii[OFF_W-1:1] == acc.off[OFF_W-1:1]) begin
            wr_hit[i]  = 1'b1;
            wr_byte[i] = ii[0] ? acc.wdata[WORD_W-1:BYTE_W] : acc.wdata[BYTE_W-1:0];
          end
        end else if (ii == acc.off) begin
          wr_hit[i]  = 1'b1;
          wr_byte[i] = acc.wdata[BYTE_W-1:0];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      map_en    <= 1'b0;
      rom_page  <= 1'b0;
      rs_ext    <= 1'b0;
      cable_sel <= 1'b0;
    end else begin
      if (wr_hit[CR_MODE_OFF]) begin
        map_en   <= wr_byte[CR_MODE_OFF][MAP_BIT];
        rom_page <= wr_byte[CR_MODE_OFF][PAGE_BIT];
      end
      if (wr_hit[CR_EXT_OFF])   rs_ext    <= wr_byte[CR_EXT_OFF][EXT_BIT];
      if (wr_hit[CR_CABLE_OFF]) cable_sel <= wr_byte[CR_CABLE_OFF][CABLE_BIT];
    end
  end

  // R2: the bank only changes on a write into it
  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable({map_en, rom_page, rs_ext, cable_sel}));
endmodule

// File: rtl/hw_id_rom.sv
module hw_id_rom
  import hostwin_pkg::*;
#(
  parameter logic [BYTE_W-1:0] MFR_ID    = 8'h4D,
  parameter logic [BYTE_W-1:0] CARD_TYPE = 8'h08,
  parameter logic [BYTE_W-1:0] CARD_REV  = 8'h02
) (
  input  logic                        page,
  input  logic                        word,
  input  logic [OFF_W-1:0]            off,
  input  logic [CFG_BYTES*BYTE_W-1:0] cfg_mirror,
  input  logic [STA_BYTES*BYTE_W-1:0] station_addr,
  output logic [WORD_W-1:0]           rd_data
);
  logic [BYTE_W-1:0] pg0 [WIN_BYTES];
  logic [BYTE_W-1:0] pg1 [WIN_BYTES];
  logic [BYTE_W-1:0] cur [WIN_BYTES];
  logic [OFF_W-1:0]  lo_idx, hi_idx;

  always_comb begin
    for (int i = 0; i < WIN_BYTES; i++) begin
      pg0[i] = '0;
      pg1[i] = '0;
    end
    pg0[0] = MFR_ID;
    pg0[1] = CARD_TYPE;
    pg0[2] = CARD_REV;
    for (int k = 0; k < CFG_BYTES; k++)
      pg0[ROM_CFG_BASE + k] = cfg_mirror[BYTE_W*k +: BYTE_W];
    for (int k = 0; k < STA_BYTES; k++)
      pg1[ROM_STA_BASE + k] = station_addr[BYTE_W*(STA_BYTES-1-k) +: BYTE_W];
    for (int i = 0; i < WIN_BYTES; i++)
      cur[i] = page ? pg1[i] : pg0[i];
  end

  assign lo_idx  = word ? {off[OFF_W-1:1], 1'b0} : off;
  assign hi_idx  = {off[OFF_W-1:1], 1'b1};
  assign rd_data = word ? {cur[hi_idx], cur[lo_idx]} : {{BYTE_W{1'b0}}, cur[off]};
endmodule

// File: rtl/hw_sif_port.sv
module hw_sif_port
  import hostwin_pkg::*;
(
  input  logic              go,
  input  hw_access_t        acc,
  input  logic              rs_ext,
  input  logic [WORD_W-1:0] sif_rdata,
  output logic              sif_cs,
  output logic              sif_we,
  output logic [RS_W-1:0]   sif_rs,
  output logic [1:0]        sif_be,
  output logic [WORD_W-1:0] sif_wdata,
  output logic [WORD_W-1:0] rd_data
);
  assign sif_cs    = go;
  assign sif_we    = go & acc.write;
  assign sif_rs    = {rs_ext, acc.off[OFF_W-1:1]};
  assign sif_be    = acc.word ? 2'b11 : (acc.off[0] ? 2'b10 : 2'b01);
  assign sif_wdata = acc.word ? acc.wdata
                              : {acc.wdata[BYTE_W-1:0], acc.wdata[BYTE_W-1:0]};
  assign rd_data   = acc.word ? sif_rdata
                   : {{BYTE_W{1'b0}},
                      (acc.off[0] ? sif_rdata[WORD_W-1:BYTE_W] : sif_rdata[BYTE_W-1:0])};
endmodule

// File: rtl/hostwin_decoder.sv
module hostwin_decoder
  import hostwin_pkg::*;
#(
  parameter logic [7:0] MFR_ID    = 8'h4D,
  parameter logic [7:0] CARD_TYPE = 8'h08,
  parameter logic [7:0] CARD_REV  = 8'h02
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        h_valid,
  output logic        h_ready,
  input  logic        h_write,
  input  logic        h_word,
  input  logic [3:0]  h_addr,
  input  logic [15:0] h_wdata,
  output logic        r_valid,
  input  logic        r_ready,
  output logic [15:0] r_data,
  input  logic [23:0] cfg_mirror,
  input  logic [47:0] station_addr,
  output logic        sif_cs,
  output logic        sif_we,
  output logic [2:0]  sif_rs,
  output logic [1:0]  sif_be,
  output logic [15:0] sif_wdata,
  input  logic [15:0] sif_rdata,
  output logic        cable_utp
);
  hw_access_t        acc;
  logic              accept, in_win;
  logic              map_en, rom_page, rs_ext;
  logic [WORD_W-1:0] ctl_rd, rom_rd, sif_rd, rd_mux;

  assign acc     = '{write: h_write, word: h_word, off: h_addr[OFF_W-1:0], wdata: h_wdata};
  assign in_win  = h_addr[OFF_W];
  assign h_ready = !r_valid || r_ready;
  assign accept  = h_valid && h_ready;

  hw_ctl_bank u_ctl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(accept && h_write && !in_win),
    .acc(acc), .rd_data(ctl_rd),
    .map_en(map_en), .rom_page(rom_page), .rs_ext(rs_ext), .cable_sel(cable_utp)
  );

  hw_id_rom #(.MFR_ID(MFR_ID), .CARD_TYPE(CARD_TYPE), .CARD_REV(CARD_REV)) u_rom (
    .page(rom_page), .word(h_word), .off(h_addr[OFF_W-1:0]),
    .cfg_mirror(cfg_mirror), .station_addr(station_addr), .rd_data(rom_rd)
  );

  hw_sif_port u_sif (
    .go(accept && in_win && map_en), .acc(acc), .rs_ext(rs_ext),
    .sif_rdata(sif_rdata), .sif_cs(sif_cs), .sif_we(sif_we), .sif_rs(sif_rs),
    .sif_be(sif_be), .sif_wdata(sif_wdata), .rd_data(sif_rd)
  );

  assign rd_mux = !in_win ? ctl_rd : (map_en ? sif_rd : rom_rd);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_valid <= 1'b0;
      r_data  <= '0;
    end else if (accept && !h_write) begin
      r_valid <= 1'b1;
      r_data  <= rd_mux;
    end else if (r_ready) begin
      r_valid <= 1'b0;
    end
  end

  // R4: no chip-select while the ROM is mapped
  p_cs_needs_map_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sif_cs |-> map_en);
  // R9: chip-select only in an accept cycle, upper select line follows extension
  p_cs_on_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sif_cs |-> (h_valid && h_ready && h_addr[3]));
  p_rs_ext_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sif_cs |-> (sif_rs[2] == rs_ext));
  // R11: held response stays put; a read gives a beat next cycle
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (r_valid && !r_ready) |=> (r_valid && $stable(r_data)));
  p_read_beat_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && !h_write) |=> r_valid);
  // R12: writes make no beat
  p_no_write_beat_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_write) |=> !r_valid);
  // R3: cable pin follows a byte write to offset 7
  p_cable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (h_valid && h_ready && h_write && !h_word && h_addr == 4'd7)
      |=> (cable_utp == $past(h_wdata[0])));
endmodule

// File: tb/sim_hostwin_decoder.sv
`timescale 1ns/1ps
module sim_hostwin_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic h_valid = 1'b0, h_write = 1'b0, h_word = 1'b0, r_ready = 1'b1;
  logic [3:0] h_addr = '0;
  logic [15:0] h_wdata = '0;
  logic h_ready, r_valid, sif_cs, sif_we, cable_utp;
  logic [15:0] r_data, sif_wdata, sif_rdata;
  logic [2:0] sif_rs;
  logic [1:0] sif_be;
  logic [23:0] cfg_mirror = 24'h53_A1_C7;
  logic [47:0] station_addr = 48'h00_20_35_8E_4B_F1;

  int n_chk = 0, n_bad = 0, cs_cnt = 0;
  logic [15:0] mem [8];
  logic [15:0] exp_mem [8];
  logic [2:0] last_rs;
  logic [1:0] last_be;
  logic sh_map = 0, sh_page = 0, sh_ext = 0, sh_cable = 0;

  always #2.5 clk = ~clk;

  hostwin_decoder u0 (
    .clk(clk), .rst_n(rst_n), .h_valid(h_valid), .h_ready(h_ready), .h_write(h_write),
    .h_word(h_word), .h_addr(h_addr), .h_wdata(h_wdata), .r_valid(r_valid),
    .r_ready(r_ready), .r_data(r_data), .cfg_mirror(cfg_mirror),
    .station_addr(station_addr), .sif_cs(sif_cs), .sif_we(sif_we), .sif_rs(sif_rs),
    .sif_be(sif_be), .sif_wdata(sif_wdata), .sif_rdata(sif_rdata), .cable_utp(cable_utp)
  );

  // controller model
  assign sif_rdata = mem[sif_rs];
  always @(posedge clk) begin
    if (sif_cs) begin
      cs_cnt  <= cs_cnt + 1;
      last_rs <= sif_rs;
      last_be <= sif_be;
      if (sif_we) begin
        if (sif_be[0]) mem[sif_rs][7:0]  <= sif_wdata[7:0];
        if (sif_be[1]) mem[sif_rs][15:8] <= sif_wdata[15:8];
      end
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act,
                       input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rom_b(input logic pg, input int i);
    if (!pg) begin
      case (i)
        0: return 8'h4D;
        1: return 8'h08;
        2: return 8'h02;
        3, 4, 5: return cfg_mirror[8*(i-3) +: 8];
        default: return 8'h00;
      endcase
    end
    if (i >= 1 && i <= 6) return station_addr[8*(6-i) +: 8];
    return 8'h00;
  endfunction

  function automatic logic [7:0] ctl_b(input int i);
    case (i)
      0: return {4'b0, sh_page, sh_map, 2'b0};
      1: return {4'b0, sh_ext, 3'b0};
      7: return {7'b0, sh_cable};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [15:0] exp_rd(input logic word, input logic [3:0] a);
    int o = int'(a[2:0]);
    int lo = o & 6;
    int hi = o | 1;
    logic [2:0] idx = {sh_ext, a[2:1]};
    if (!a[3]) return word ? {ctl_b(hi), ctl_b(lo)} : {8'h00, ctl_b(o)};
    if (sh_map) return word ? exp_mem[idx] : {8'h00, (a[0] ? exp_mem[idx][15:8] : exp_mem[idx][7:0])};
    return word ? {rom_b(sh_page, hi), rom_b(sh_page, lo)} : {8'h00, rom_b(sh_page, o)};
  endfunction

  task automatic do_acc(input logic wr, input logic word, input logic [3:0] a,
                        input logic [15:0] wd, output logic [15:0] d);
    @(negedge clk);
    h_valid = 1'b1; h_write = wr; h_word = word; h_addr = a; h_wdata = wd;
    while (!h_ready) @(negedge clk);
    @(posedge clk);
    #1 h_valid = 1'b0;
    @(negedge clk);
    d = r_valid ? r_data : 16'hxxxx;
  endtask

  task automatic rd_chk(input string req, input logic word, input logic [3:0] a);
    logic [15:0] d;
    do_acc(1'b0, word, a, 16'h0, d);
    check(req, $sformatf("read w=%0d a=%0d", word, a), d, exp_rd(word, a));
  endtask

  task automatic wr(input logic word, input logic [3:0] a, input logic [15:0] wd);
    logic [15:0] d;
    do_acc(1'b1, word, a, wd, d);
  endtask

  task automatic set_mode(input logic m, input logic p, input logic e, input logic c);
    wr(1'b0, 4'd0, 16'h00F3 | {12'h0, p, m, 2'b0});
    wr(1'b0, 4'd1, 16'h00F7 | {12'h0, e, 3'b0});
    wr(1'b0, 4'd7, 16'h00FE | {15'h0, c});
    sh_map = m; sh_page = p; sh_ext = e; sh_cable = c;
  endtask

  task automatic sweep_all(input string req_rom);
    for (int a = 0; a < 16; a++) begin
      int c0 = cs_cnt;
      rd_chk(a < 8 ? "R2" : (sh_map ? "R9" : req_rom), 1'b0, 4'(a));
      if (a >= 8) begin
        check(sh_map ? "R9" : "R4", "cs count", 16'(cs_cnt - c0), sh_map ? 16'd1 : 16'd0);
        if (sh_map) begin
          check("R9", "rs", {13'h0, last_rs}, {13'h0, sh_ext, 2'(a >> 1)});
          check("R9", "be", {14'h0, last_be}, (a % 2) ? 16'd2 : 16'd1);
        end
      end
    end
    for (int a = 0; a < 16; a += 2) begin
      rd_chk(a < 8 ? "R2" : (sh_map ? "R9" : "R7"), 1'b1, 4'(a));
      if (a >= 8 && sh_map) check("R9", "word be", {14'h0, last_be}, 16'd3);
    end
    rd_chk("R7", 1'b1, 4'd13);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
    $finish;
  end

  initial begin : main
    logic [15:0] d;
    for (int i = 0; i < 8; i++) begin
      mem[i] = 16'h1111 * 16'(i) ^ 16'h5A3C;
      exp_mem[i] = mem[i];
    end
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "r_valid", {15'h0, r_valid}, 16'h0);
    check("R1", "cable", {15'h0, cable_utp}, 16'h0);
    for (int a = 0; a < 8; a++) rd_chk("R1", 1'b0, 4'(a));
    rd_chk("R4", 1'b0, 4'd8);

    // mode sweep: map, page, ext, cable
    for (int c = 0; c < 16; c++) begin
      set_mode(c[0], c[1], c[2], c[3]);
      check("R3", "cable pin", {15'h0, cable_utp}, {15'h0, sh_cable});
      sweep_all(sh_page ? "R6" : "R5");
    end

    // second identity pattern
    cfg_mirror = 24'h0F_E2_96;
    station_addr = 48'hA5_5A_C3_3C_10_01;
    for (int p = 0; p < 2; p++) begin
      set_mode(1'b0, p[0], 1'b1, 1'b1);
      sweep_all(p ? "R6" : "R5");
    end

    // R10 controller writes
    for (int e = 0; e < 2; e++) begin
      set_mode(1'b1, 1'b0, e[0], 1'b0);
      for (int w = 0; w < 4; w++) begin
        logic [15:0] v = 16'hC000 + 16'(e * 64 + w * 7);
        wr(1'b1, 4'(8 + 2 * w), v);
        exp_mem[e * 4 + w] = v;
        check("R10", "word write", mem[e * 4 + w], v);
        wr(1'b0, 4'(9 + 2 * w), 16'hEE00 | 16'(w + 16 * e));
        exp_mem[e * 4 + w][15:8] = 8'(w + 16 * e);
        check("R10", "hi byte write", mem[e * 4 + w], exp_mem[e * 4 + w]);
        check("R10", "hi be", {14'h0, last_be}, 16'd2);
      end
      wr(1'b0, 4'd8, 16'h0077);
      exp_mem[e * 4][7:0] = 8'h77;
      check("R10", "lo byte write", mem[e * 4], exp_mem[e * 4]);
      for (int a = 8; a < 16; a += 2) rd_chk("R10", 1'b1, 4'(a));
    end

    // R8 writes to ROM view ignored
    for (int p = 0; p < 2; p++) begin
      int c0;
      set_mode(1'b0, p[0], 1'b0, 1'b0);
      c0 = cs_cnt;
      for (int a = 8; a < 16; a++) wr(1'b0, 4'(a), 16'h00FF);
      wr(1'b1, 4'd10, 16'hFFFF);
      check("R8", "cs count", 16'(cs_cnt - c0), 16'd0);
      for (int i = 0; i < 8; i++) check("R8", "ctrl model", mem[i], exp_mem[i]);
      for (int a = 8; a < 16; a++) rd_chk("R8", 1'b0, 4'(a));
    end

    // R12 write gives no beat
    wr(1'b0, 4'd3, 16'h00FF);
    check("R12", "r_valid after write", {15'h0, r_valid}, 16'h0);
    rd_chk("R2", 1'b0, 4'd3);

    // R11 back-pressure
    @(negedge clk);
    r_ready = 1'b0;
    h_valid = 1'b1; h_write = 1'b0; h_word = 1'b1; h_addr = 4'd8;
    @(posedge clk);
    #1 h_addr = 4'd10;
    @(negedge clk);
    check("R11", "r_valid held", {15'h0, r_valid}, 16'h1);
    d = r_data;
    check("R11", "first data", d, exp_rd(1'b1, 4'd8));
    repeat (3) begin
      @(negedge clk);
      check("R11", "h_ready low", {15'h0, h_ready}, 16'h0);
      check("R11", "data stable", r_data, d);
    end
    r_ready = 1'b1;
    @(posedge clk);
    #1 h_valid = 1'b0;
    @(negedge clk);
    check("R11", "second beat", r_data, exp_rd(1'b1, 4'd10));
    @(negedge clk);
    check("R11", "drained", {15'h0, r_valid}, 16'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule